// File: doc/BRIEF.md
# Free-Running Microsecond Interval Timer

This block keeps a 16-bit count that advances once per microsecond and never reloads. When it passes its all-ones value it wraps to zero and keeps going. Software times an event by sampling the count at the start and at the end of the event and subtracting the two samples modulo 2^16.

Two interrupt sources come from the count:

- **Interval interrupt.** It fires when the count reaches a programmed 16-bit compare value. Software schedules the next interval by adding its period to that compare value.
- **Periodic tick.** It fires each time the count crosses a multiple of 2^TICK_BIT. With the default of 10 this is every 1024 counts, or 1.024 ms.

Each source has an enable bit and a sticky pending flag. Software clears a pending flag by writing a one to it.

Access is through an 8-bit register port. The microsecond step comes from one of two places, chosen by a parameter:

- **External mode.** The `us_en` input is the step strobe.
- **Internal mode.** A built-in divider turns CLK_DIV clocks (12 for a 12 MHz clock) into one step, and `us_en` acts as a run enable for that divider.

Top module: `usec_interval_timer`

## Requirements
- R1: After reset:
  - the count is 0;
  - the active compare value is 0xFFFF;
  - both enables and both pending flags are 0;
  - both interrupt outputs are low;
  - the holding byte is 0.
- R2: The count increases by exactly one on each clock where the step is active and holds otherwise. From 0xFFFF it steps to 0x0000. Reading address 0 returns the count's low byte.
- R3: With the internal divider selected and `us_en` held high, the step is active on one clock in every CLK_DIV. After K·CLK_DIV clock edges from reset release, the count equals K.
- R4: The interval pending flag (address 5, bit 0) becomes 1 on the clock where the count steps to a value equal to the active compare value.
- R5: The tick pending flag (address 5, bit 1) becomes 1 on the clock where the count steps to a multiple of 2^TICK_BIT.
- R6: Address 4 holds the enables: bit 0 for the interval source, bit 1 for the tick. `irq_interval` is high exactly when the interval pending flag and its enable are both 1. `irq_tick` is high exactly when the tick pending flag and its enable are both 1.
- R7: Writing address 5 behaves as follows:
  - a 1 in bit 0 or bit 1 clears that pending flag;
  - a 0 leaves it unchanged;
  - if a flag is set and cleared on the same clock, it ends up set.
- R8: A read strobe at address 0 copies the count's high byte into a holding byte, which address 1 returns. The holding byte changes at no other time.
- R9: A write to address 2 only stages a low byte. A write to address 3 loads the active compare value as {written byte, staged byte}. Addresses 2 and 3 read back the active compare value, low byte and high byte. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_en | input | 1 | Step strobe (external mode) or divider run enable (internal mode) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (side effect at address 0) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| irq_interval | output | 1 | Interval interrupt request |
| irq_tick | output | 1 | Periodic tick interrupt request |

## Verification
The bench builds two instances of the block.

- **Main instance.** It uses external stepping with TICK_BIT=4, so a tick arrives every 16 steps. Because it can step on every clock, a full 65536-count wrap fits in the run. It also lets the bench place set/clear collisions and compare hits on chosen clocks, including a compare hit just past the wrap.
- **Second instance.** It uses the internal divider with CLK_DIV=5, which shows the divided step rate within a few hundred clocks.

// File: rtl/ust_pkg.sv
package ust_pkg;

   localparam int UST_BUS_W  = 8;
   localparam int UST_ADDR_W = 3;

   typedef enum logic [UST_ADDR_W-1:0] {
      UST_A_CNT_LO  = 3'd0,
      UST_A_CNT_HLD = 3'd1,
      UST_A_CMP_LO  = 3'd2,
      UST_A_CMP_HI  = 3'd3,
      UST_A_CTRL    = 3'd4,
      UST_A_PEND    = 3'd5
   } ust_addr_e;

   // bit positions inside the enable and pending registers
   localparam int UST_SRC_INTV = 0;
   localparam int UST_SRC_TICK = 1;
   localparam int UST_NSRC     = 2;

   typedef logic [UST_NSRC-1:0] ust_src_t;

endpackage

// File: rtl/ust_prescaler.sv
module ust_prescaler #(
   parameter int CLK_DIV        = 12,
   parameter bit USE_EXT_STROBE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic us_en,
   output logic step
);

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("ust_prescaler: CLK_DIV must be at least 1");
   end

   if (USE_EXT_STROBE) begin : g_ext
      assign step = us_en;
   end else if (CLK_DIV == 1) begin : g_pass
      assign step = us_en;
   end else begin : g_div
      localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (us_en) begin
            if (div_q == LAST) div_q <= '0;
            else               div_q <= div_q + DIV_W'(1);
         end
      end

      assign step = us_en && (div_q == LAST);

      AST_STEP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         step |=> !step); // R3
   end

endmodule

// File: rtl/ust_counter.sv
module ust_counter #(
   parameter int CNT_W    = 16,
   parameter int TICK_BIT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] count_nxt,
   output logic             tick_evt
);

   if (TICK_BIT < 1 || TICK_BIT >= CNT_W) begin : g_bad_tick
      $error("ust_counter: TICK_BIT must lie in 1..CNT_W-1");
   end

   assign count_nxt = count + CNT_W'(1);

   // stepping to a multiple of 2**TICK_BIT toggles bit TICK_BIT
   assign tick_evt = step && (&count[TICK_BIT-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (step) count <= count_nxt;
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (count == CNT_W'($past(count) + CNT_W'(1)))); // R2
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count)); // R2

endmodule

// File: rtl/ust_irq_unit.sv
module ust_irq_unit
   import ust_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int TICK_BIT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] count_nxt,
   input  logic             tick_evt,
   input  logic [CNT_W-1:0] cmp,
   input  ust_src_t         en,
   input  ust_src_t         clr,
   output ust_src_t         pend,
   output logic             irq_interval,
   output logic             irq_tick
);

   ust_src_t set_v;

   always_comb begin
      set_v               = '0;
      set_v[UST_SRC_INTV] = step && (count_nxt == cmp);
      set_v[UST_SRC_TICK] = tick_evt;
   end

   // set takes priority over a same-cycle clear
   for (genvar i = 0; i < UST_NSRC; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n)        pend[i] <= 1'b0;
         else if (set_v[i]) pend[i] <= 1'b1;
         else if (clr[i])   pend[i] <= 1'b0;
      end
   end

   assign irq_interval = pend[UST_SRC_INTV] & en[UST_SRC_INTV];
   assign irq_tick     = pend[UST_SRC_TICK] & en[UST_SRC_TICK];

   AST_INTV_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[UST_SRC_INTV]) |-> (count == $past(cmp))); // R4
   AST_TICK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[UST_SRC_TICK]) |-> (count[TICK_BIT-1:0] == '0)); // R5
   AST_INTV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[UST_SRC_INTV] && !clr[UST_SRC_INTV]) |=> pend[UST_SRC_INTV]); // R7
   AST_TICK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[UST_SRC_TICK] && !clr[UST_SRC_TICK]) |=> pend[UST_SRC_TICK]); // R7

endmodule

// File: rtl/ust_regs.sv
module ust_regs
   import ust_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [UST_ADDR_W-1:0] wr_addr,
   input  logic [UST_BUS_W-1:0]  wr_data,
   input  logic                  rd_en,
   input  logic [UST_ADDR_W-1:0] rd_addr,
   output logic [UST_BUS_W-1:0]  rd_data,
   input  logic [CNT_W-1:0]      count,
   input  ust_src_t              pend,
   output logic [CNT_W-1:0]      cmp,
   output ust_src_t              en,
   output ust_src_t              clr
);

   localparam int HI_W = CNT_W - UST_BUS_W;

   if (CNT_W != 2 * UST_BUS_W) begin : g_bad_width
      $error("ust_regs: CNT_W must be twice the bus width");
   end

   logic [UST_BUS_W-1:0] stage_q;
   logic [HI_W-1:0]      hold_q;

   wire wr_cmp_lo = wr_en && (wr_addr == UST_A_CMP_LO);
   wire wr_cmp_hi = wr_en && (wr_addr == UST_A_CMP_HI);
   wire wr_ctrl   = wr_en && (wr_addr == UST_A_CTRL);
   wire wr_pend   = wr_en && (wr_addr == UST_A_PEND);
   wire rd_lo     = rd_en && (rd_addr == UST_A_CNT_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         cmp     <= '1;
         en      <= '0;
         hold_q  <= '0;
      end else begin
         if (wr_cmp_lo) stage_q <= wr_data;
         if (wr_cmp_hi) cmp     <= {wr_data, stage_q};
         if (wr_ctrl)   en      <= wr_data[UST_NSRC-1:0];
         if (rd_lo)     hold_q  <= count[CNT_W-1:UST_BUS_W];
      end
   end

   assign clr = wr_pend ? wr_data[UST_NSRC-1:0] : '0;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         UST_A_CNT_LO:  rd_data = count[UST_BUS_W-1:0];
         UST_A_CNT_HLD: rd_data = hold_q;
         UST_A_CMP_LO:  rd_data = cmp[UST_BUS_W-1:0];
         UST_A_CMP_HI:  rd_data = cmp[CNT_W-1:UST_BUS_W];
         UST_A_CTRL:    rd_data = UST_BUS_W'(en);
         UST_A_PEND:    rd_data = UST_BUS_W'(pend);
         default:       rd_data = '0;
      endcase
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(hold_q)); // R8
   AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp_lo && !wr_cmp_hi) |=> $stable(cmp)); // R9

endmodule

// File: rtl/usec_interval_timer.sv
module usec_interval_timer
   import ust_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int TICK_BIT       = 10,
   parameter int CLK_DIV        = 12,
   parameter bit USE_EXT_STROBE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  us_en,
   input  logic                  wr_en,
   input  logic [UST_ADDR_W-1:0] wr_addr,
   input  logic [UST_BUS_W-1:0]  wr_data,
   input  logic                  rd_en,
   input  logic [UST_ADDR_W-1:0] rd_addr,
   output logic [UST_BUS_W-1:0]  rd_data,
   output logic                  irq_interval,
   output logic                  irq_tick
);

   logic             step;
   logic             tick_evt;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] count_nxt;
   logic [CNT_W-1:0] cmp;
   ust_src_t         en;
   ust_src_t         clr;
   ust_src_t         pend;

   ust_prescaler #(
      .CLK_DIV        (CLK_DIV),
      .USE_EXT_STROBE (USE_EXT_STROBE)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .us_en (us_en),
      .step  (step)
   );

   ust_counter #(
      .CNT_W    (CNT_W),
      .TICK_BIT (TICK_BIT)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .count     (count),
      .count_nxt (count_nxt),
      .tick_evt  (tick_evt)
   );

   ust_irq_unit #(
      .CNT_W    (CNT_W),
      .TICK_BIT (TICK_BIT)
   ) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (step),
      .count        (count),
      .count_nxt    (count_nxt),
      .tick_evt     (tick_evt),
      .cmp          (cmp),
      .en           (en),
      .clr          (clr),
      .pend         (pend),
      .irq_interval (irq_interval),
      .irq_tick     (irq_tick)
   );

   ust_regs #(
      .CNT_W (CNT_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .count   (count),
      .pend    (pend),
      .cmp     (cmp),
      .en      (en),
      .clr     (clr)
   );

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == UST_A_CTRL && wr_data[UST_SRC_INTV] == 1'b0)
         |=> !irq_interval); // R6

endmodule

// File: tb/usec_interval_timer_tb.sv
`timescale 1ns/1ps
module usec_interval_timer_tb_top;

   localparam int TB_TICK   = 4;
   localparam int TB_TPER   = 1 << TB_TICK;
   localparam int TB_DIV    = 5;
   localparam int WATCHDOG  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb = 1'b0;
   logic       we = 1'b0;
   logic [2:0] wa = '0;
   logic [7:0] wd = '0;
   logic       re = 1'b0;
   logic [2:0] ra = '0;
   logic [7:0] rdat;
   logic       irq_i, irq_t;

   logic [7:0] rdat_ps;
   logic       irq_i_ps, irq_t_ps;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // reference model state
   int       m_cnt, m_cmp, m_stage, m_hold;
   bit [1:0] m_en, m_pend;

   always #2 clk = ~clk;

   usec_interval_timer #(
      .CNT_W(16), .TICK_BIT(TB_TICK), .CLK_DIV(12), .USE_EXT_STROBE(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .us_en(stb), .wr_en(we), .wr_addr(wa),
      .wr_data(wd), .rd_en(re), .rd_addr(ra), .rd_data(rdat),
      .irq_interval(irq_i), .irq_tick(irq_t)
   );

   usec_interval_timer #(
      .CNT_W(16), .TICK_BIT(10), .CLK_DIV(TB_DIV), .USE_EXT_STROBE(1'b0)
   ) dut_ps_i (
      .clk(clk), .rst_n(rst_n), .us_en(1'b1), .wr_en(1'b0), .wr_addr(3'd0),
      .wr_data(8'd0), .rd_en(1'b0), .rd_addr(3'd0), .rd_data(rdat_ps),
      .irq_interval(irq_i_ps), .irq_tick(irq_t_ps)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 'hFFFF; m_stage = 0; m_hold = 0; m_en = 0; m_pend = 0;
      end else begin
         int       nxt;
         bit [1:0] p;
         nxt = (m_cnt + 1) % 65536;
         p   = m_pend;
         if (we && wa == 3'd5) p = p & ~wd[1:0];
         if (stb && nxt == m_cmp)       p[0] = 1'b1;
         if (stb && (nxt % TB_TPER) == 0) p[1] = 1'b1;
         if (re && ra == 3'd0) m_hold = m_cnt / 256;
         if (we) begin
            case (wa)
               3'd2: m_stage = wd;
               3'd3: m_cmp = wd * 256 + m_stage;
               3'd4: m_en = wd[1:0];
               default: ;
            endcase
         end
         if (stb) m_cnt = nxt;
         m_pend = p;
      end
   end

   function automatic int exp_rd(input int a);
      case (a)
         0: return m_cnt % 256;
         1: return m_hold;
         2: return m_cmp % 256;
         3: return m_cmp / 256;
         4: return m_en;
         5: return m_pend;
         default: return 0;
      endcase
   endfunction

   function automatic string rd_req(input int a);
      case (a)
         0: return "R2";
         1: return "R8";
         4: return "R6";
         5: return "R7";
         default: return "R9";
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         check(rdat == 8'(exp_rd(ra)), rd_req(ra), rdat, exp_rd(ra));
         check(irq_i == (m_pend[0] & m_en[0]), "R6", irq_i, m_pend[0] & m_en[0]);
         check(irq_t == (m_pend[1] & m_en[1]), "R6", irq_t, m_pend[1] & m_en[1]);
      end
   end

   task automatic cyc(input bit s, input bit w, input int a, input int d,
                      input bit r, input int ra_v);
      @(negedge clk);
      stb = s; we = w; wa = 3'(a); wd = 8'(d); re = r; ra = 3'(ra_v);
   endtask

   task automatic peek(input int a);
      cyc(0, 0, 0, 0, 0, a);
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      wait (cycles >= WATCHDOG);
      check(1'b0, "WATCHDOG", cycles, WATCHDOG);
      finish_run();
   end

   initial begin
      int c0, h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R3: divided step rate on the second instance
      repeat (99) @(posedge clk);
      #1; check(rdat_ps == 8'd19, "R3", rdat_ps, 19);
      @(posedge clk);
      #1; check(rdat_ps == 8'd20, "R3", rdat_ps, 20);

      // R1: reset values
      peek(0); check(rdat == 8'd0, "R1", rdat, 0);
      peek(2); check(rdat == 8'hFF, "R1", rdat, 'hFF);
      peek(3); check(rdat == 8'hFF, "R1", rdat, 'hFF);
      peek(5); check(rdat == 8'd0, "R1", rdat, 0);
      check(irq_i == 1'b0 && irq_t == 1'b0, "R1", {irq_i, irq_t}, 0);

      // R6: enable both sources; R9: compare = 0x0028
      cyc(0, 1, 4, 3, 0, 0);
      cyc(0, 1, 2, 'h28, 0, 0);
      cyc(0, 1, 3, 'h00, 0, 0);
      peek(2); check(rdat == 8'h28, "R9", rdat, 'h28);
      for (int i = 0; i < 40; i++) cyc(1, 0, 0, 0, 0, 5);
      peek(0); check(rdat == 8'd40, "R2", rdat, 40);
      check(irq_i == 1'b1, "R4", irq_i, 1);
      peek(5); check(rdat[1] == 1'b1, "R5", rdat, 2);

      // R7: writing zero leaves flags, writing one clears
      cyc(0, 1, 5, 0, 0, 5);
      peek(5); check(rdat[1:0] == 2'b11, "R7", rdat, 3);
      cyc(0, 1, 5, 1, 0, 5);
      peek(5); check(rdat[1:0] == 2'b10, "R7", rdat, 2);
      cyc(0, 1, 5, 2, 0, 5);
      peek(5); check(rdat[1:0] == 2'b00, "R7", rdat, 0);

      // R5: tick only on reaching a multiple of 2**TICK_BIT (count now 40)
      for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 0, 5);
      peek(5); check(rdat[1] == 1'b0, "R5", rdat, 0);
      cyc(1, 0, 0, 0, 0, 5);
      peek(5); check(rdat[1] == 1'b1, "R5", rdat, 2);

      // R9: staging the low byte alone keeps the active compare
      cyc(0, 1, 2, 'h50, 0, 2);
      peek(2); check(rdat == 8'h28, "R9", rdat, 'h28);
      peek(6); check(rdat == 8'h00, "R9", rdat, 0);

      // R7: set and clear on the same clock, set wins (count now 48)
      cyc(0, 1, 2, 49, 0, 0);
      cyc(0, 1, 3, 0, 0, 0);
      cyc(0, 1, 5, 1, 0, 5);
      cyc(1, 1, 5, 1, 0, 5);
      peek(5); check(rdat[0] == 1'b1, "R7", rdat, 1);

      // R6: disabled source keeps its flag but drops its request
      cyc(0, 1, 4, 2, 0, 5);
      peek(5); check(irq_i == 1'b0 && rdat[0] == 1'b1, "R6", irq_i, 0);

      // pattern with gaps in the step, mixed reads
      for (int i = 0; i < 300; i++) cyc((i % 3) != 0, 0, 0, 0, (i % 7) == 0, i % 8);

      // R8: holding byte captured only by an address-0 read
      cyc(0, 0, 0, 0, 1, 0);
      h0 = m_cnt / 256;
      for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, 0, 1);
      peek(1); check(rdat == 8'(h0), "R8", rdat, h0);

      // R2 and R4 across the wrap: compare = 0x0002
      cyc(0, 1, 2, 2, 0, 0);
      cyc(0, 1, 3, 0, 0, 0);
      cyc(0, 1, 5, 3, 0, 0);
      cyc(0, 1, 4, 1, 1, 0);
      c0 = m_cnt;
      for (int i = 0; i < 65536; i++) cyc(1, 0, 0, 0, 0, 0);
      peek(0); check(rdat == 8'(c0 % 256), "R2", rdat, c0 % 256);
      cyc(0, 0, 0, 0, 1, 0);
      peek(1); check(rdat == 8'(c0 / 256), "R2", rdat, c0 / 256);
      check(irq_i == 1'b1, "R4", irq_i, 1);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule